// File: doc/BRIEF.md
# Clock Phase Alignment Controller

This block derives a slower synchronization clock from a fast system clock and lets the phase of that clock be moved later in steps of exactly one system-clock cycle. The divided clock comes from a free-running 2-bit counter, so it runs at one quarter of the system clock rate. A slip holds the counter for one cycle. Every edge that follows then arrives one system-clock cycle later than it otherwise would.

A slip is requested in one of two ways. Software writes a self-clearing advance bit, seen here as a one-cycle write strobe. Each write asks for one slip, and the bit can be written as often as needed. The other way uses a shared pin. When step mode is selected, every rising edge on the pin asks for one slip. The edge is first passed through a two-flop synchronizer and an edge detector. When neither step mode nor the automatic-sync mode bits are set, the same pin drives the lock indication out. When step mode is on, the pin is an input, and a loss of lock raises a sticky out-of-lock flag instead. Software clears that flag by writing 1.

Requests that come in together, or while a slip is still in progress, are counted and carried out one after another. No request is lost until the counter saturates.

Top module: `sync_phase_ctrl`

## Requirements
- R1: After reset all mode bits are taken as 0. The divided clock is low, the out-of-lock flag is 0, and the pin is driven (`pad_oe` = 1).
- R2: With no slip requests, `sync_clk` is high exactly when (system-clock edges since reset − slips completed) mod 4 is 2 or 3. It is low when that value is 0 or 1.
- R3: Each cycle in which `sw_adv_wr` is 1 asks for exactly one slip. Writes may repeat without limit, and writes in back-to-back cycles each count once.
- R4: While no request is made, `sync_clk` keeps its current phase relation to the system clock.
- R5: When step mode (`mode_step` = 1) is in effect, each rising edge of `pad_in` asks for one slip. The edge is used after a two-flop synchronizer. Edges on `pad_in` are ignored when step mode is off.
- R6: A software request and a pin request detected in the same cycle are both honored. The counter is then held for two consecutive cycles.
- R7: The pin mode follows the mode bits one cycle later. With `mode_step` = 1 the pin is a step input. Otherwise, if `mode_auto` or `mode_fast` is 1, the pin is a reference input. Otherwise the pin drives `lock_in` out. `pad_oe` is 1 only in the lock-output mode. `pad_out` equals `lock_in` there and is 0 in the other modes.
- R8: In step mode, a 1→0 transition of `lock_in` sets `oolock_flag` on the following edge. The flag stays set until a cycle with `flag_clr` = 1 clears it. A new loss of lock in the clearing cycle wins over the clear.
- R9: Outside step mode, a loss of lock does not set `oolock_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_sys | input | 1 | Fast system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_step | input | 1 | Step-mode bit: the pin becomes a slip-request input |
| mode_auto | input | 1 | Automatic-sync mode bit; only selects the pin direction |
| mode_fast | input | 1 | High-speed auto-sync mode bit; only selects the pin direction |
| sw_adv_wr | input | 1 | One-cycle write of 1 to the self-clearing advance bit |
| lock_in | input | 1 | Loop lock indication, 1 = locked |
| flag_clr | input | 1 | Write of 1 to the out-of-lock flag, which clears it |
| pad_in | input | 1 | Value seen on the shared pin |
| sync_clk | output | 1 | Divided synchronization clock |
| oolock_flag | output | 1 | Sticky out-of-lock flag |
| pad_oe | output | 1 | Output enable of the shared pin |
| pad_out | output | 1 | Value driven on the shared pin |

## Verification
The hardest case to produce from the ports is a pin request and a software write landing in the same cycle. The pin edge takes a variable path through the synchronizer before it turns into a request. The bench raises `pad_in` just before one edge and then places the one-cycle software write exactly two edges later, at four different starting phases of the divided clock. It then compares the settled phase with an expected phase that counts two slips. Step-mode edges sent while the pin is an output or a reference input show that ignored requests leave the phase unchanged. The set-and-clear collision on the flag is driven in a single cycle.

// File: rtl/sync_phase_pkg.sv
package sync_phase_pkg;

    // Role of the shared pin
    typedef enum logic [1:0] {
        PIN_LOCK_OUT = 2'd0,
        PIN_STEP_IN  = 2'd1,
        PIN_REF_IN   = 2'd2
    } pin_mode_e;

    // Slip sequencer states
    typedef enum logic {
        SLIP_RUN  = 1'b0,
        SLIP_HOLD = 1'b1
    } slip_state_e;

endpackage

// File: rtl/sync_pin_edge.sv
module sync_pin_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_sys,
    input  logic rst_n,
    input  logic pin_in,
    input  logic enable,
    output logic rise_pulse
);
    localparam int SHR_W = SYNC_STAGES + 1;

    logic [SHR_W-1:0] shr_q;

    // Synchronizer chain plus one history stage for edge detection
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            shr_q <= '0;
        end else begin
            shr_q <= {shr_q[SHR_W-2:0], pin_in};
        end
    end

    always_comb begin
        rise_pulse = enable & shr_q[SHR_W-2] & ~shr_q[SHR_W-1];
    end

endmodule

// File: rtl/sync_slip_seq.sv
module sync_slip_seq
    import sync_phase_pkg::*;
#(
    parameter int DIV_W  = 2,
    parameter int DEBT_W = 3
) (
    input  logic             clk_sys,
    input  logic             rst_n,
    input  logic             sw_req,
    input  logic             hw_req,
    output logic [DIV_W-1:0] div_cnt,
    output logic             slip_hold,
    output logic             debt_zero
);
    localparam int SUM_W = DEBT_W + 1;
    localparam logic [SUM_W-1:0] DEBT_MAX = SUM_W'((1 << DEBT_W) - 1);

    slip_state_e       state_q, state_d;
    logic [DEBT_W-1:0] debt_q, debt_d;
    logic [SUM_W-1:0]  debt_sum;
    logic [1:0]        req_cnt;

    // Next-state and owed-slip arithmetic
    always_comb begin
        req_cnt  = {1'b0, sw_req} + {1'b0, hw_req};
        debt_sum = SUM_W'(debt_q) + SUM_W'(req_cnt);
        if (state_q == SLIP_HOLD) begin
            debt_sum = debt_sum - 1'b1;
        end
        debt_d  = (debt_sum > DEBT_MAX) ? DEBT_MAX[DEBT_W-1:0] : debt_sum[DEBT_W-1:0];
        state_d = state_q;
        unique case (state_q)
            SLIP_RUN:  if (req_cnt != 2'd0) state_d = SLIP_HOLD;
            SLIP_HOLD: if (debt_sum == '0)  state_d = SLIP_RUN;
            default:   state_d = SLIP_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLIP_RUN;
            debt_q  <= '0;
        end else begin
            state_q <= state_d;
            debt_q  <= debt_d;
        end
    end

    // Outputs
    always_comb begin
        slip_hold = (state_q == SLIP_HOLD);
        debt_zero = (debt_q == '0);
    end

    // Divider counter, frozen for one cycle per slip
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            div_cnt <= '0;
        end else if (!slip_hold) begin
            div_cnt <= div_cnt + 1'b1;
        end
    end

endmodule

// File: rtl/sync_pin_mode.sv
module sync_pin_mode
    import sync_phase_pkg::*;
(
    input  logic clk_sys,
    input  logic rst_n,
    input  logic mode_step,
    input  logic mode_auto,
    input  logic mode_fast,
    input  logic lock_in,
    output logic pad_oe,
    output logic pad_out,
    output logic step_sel
);
    pin_mode_e mode_q, mode_d;

    always_comb begin
        if (mode_step) begin
            mode_d = PIN_STEP_IN;
        end else if (mode_auto | mode_fast) begin
            mode_d = PIN_REF_IN;
        end else begin
            mode_d = PIN_LOCK_OUT;
        end
    end

    // State register
    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= PIN_LOCK_OUT;
        end else begin
            mode_q <= mode_d;
        end
    end

    // Outputs
    always_comb begin
        pad_oe   = 1'b0;
        pad_out  = 1'b0;
        step_sel = 1'b0;
        unique case (mode_q)
            PIN_LOCK_OUT: begin
                pad_oe  = 1'b1;
                pad_out = lock_in;
            end
            PIN_STEP_IN:  step_sel = 1'b1;
            PIN_REF_IN:   ;
            default:      ;
        endcase
    end

endmodule

// File: rtl/sync_lock_flag.sv
module sync_lock_flag (
    input  logic clk_sys,
    input  logic rst_n,
    input  logic lock_in,
    input  logic arm,
    input  logic clr,
    output logic flag
);
    logic lock_q;
    logic loss;

    always_comb begin
        loss = arm & lock_q & ~lock_in;
    end

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= 1'b0;
            flag   <= 1'b0;
        end else begin
            lock_q <= lock_in;
            if (loss) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/sync_phase_ctrl.sv
module sync_phase_ctrl #(
    parameter int DIV_W       = 2,
    parameter int DEBT_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk_sys,
    input  logic rst_n,
    input  logic mode_step,
    input  logic mode_auto,
    input  logic mode_fast,
    input  logic sw_adv_wr,
    input  logic lock_in,
    input  logic flag_clr,
    input  logic pad_in,
    output logic sync_clk,
    output logic oolock_flag,
    output logic pad_oe,
    output logic pad_out
);
    logic             hw_sel;
    logic             hw_edge;
    logic             slip_hold;
    logic             debt_zero;
    logic [DIV_W-1:0] div_cnt;

    sync_pin_mode u_pin_mode (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .mode_step (mode_step),
        .mode_auto (mode_auto),
        .mode_fast (mode_fast),
        .lock_in   (lock_in),
        .pad_oe    (pad_oe),
        .pad_out   (pad_out),
        .step_sel  (hw_sel)
    );

    sync_pin_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pin_edge (
        .clk_sys    (clk_sys),
        .rst_n      (rst_n),
        .pin_in     (pad_in),
        .enable     (hw_sel),
        .rise_pulse (hw_edge)
    );

    sync_slip_seq #(.DIV_W(DIV_W), .DEBT_W(DEBT_W)) u_slip_seq (
        .clk_sys   (clk_sys),
        .rst_n     (rst_n),
        .sw_req    (sw_adv_wr),
        .hw_req    (hw_edge),
        .div_cnt   (div_cnt),
        .slip_hold (slip_hold),
        .debt_zero (debt_zero)
    );

    sync_lock_flag u_lock_flag (
        .clk_sys (clk_sys),
        .rst_n   (rst_n),
        .lock_in (lock_in),
        .arm     (hw_sel),
        .clr     (flag_clr),
        .flag    (oolock_flag)
    );

    assign sync_clk = div_cnt[DIV_W-1];

endmodule

// File: rtl/sync_phase_ctrl_chk.sv
module sync_phase_ctrl_chk #(
    parameter int DIV_W = 2
) (
    input logic             clk_sys,
    input logic             rst_n,
    input logic             sw_adv_wr,
    input logic             flag_clr,
    input logic             pad_oe,
    input logic             pad_out,
    input logic             oolock_flag,
    input logic             hw_sel,
    input logic             hw_edge,
    input logic             slip_hold,
    input logic             debt_zero,
    input logic [DIV_W-1:0] div_cnt
);
    logic seen_q;

    always_ff @(posedge clk_sys or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= 1'b1;
    end

    AST_CNT_STEP: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        !slip_hold |=> div_cnt == DIV_W'($past(div_cnt) + 1'b1)); // R2
    AST_CNT_FROZEN: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        slip_hold |=> $stable(div_cnt)); // R3
    AST_SW_SLIP: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        (sw_adv_wr && debt_zero) |=> slip_hold); // R3
    AST_DOUBLE_HOLD: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        (sw_adv_wr && hw_edge && debt_zero) |=> slip_hold ##1 slip_hold); // R6
    AST_EDGE_GATED: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        hw_edge |-> hw_sel); // R5
    AST_STEP_NO_DRIVE: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        hw_sel |-> !pad_oe); // R7
    AST_PAD_QUIET: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        !pad_oe |-> !pad_out); // R7
    AST_FLAG_HOLD: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        (oolock_flag && !flag_clr) |=> oolock_flag); // R8
    AST_FLAG_ARMED: assert property (@(posedge clk_sys) disable iff (!rst_n || !seen_q)
        $rose(oolock_flag) |-> $past(hw_sel)); // R9

endmodule

bind sync_phase_ctrl sync_phase_ctrl_chk #(.DIV_W(DIV_W)) u_chk (
    .clk_sys     (clk_sys),
    .rst_n       (rst_n),
    .sw_adv_wr   (sw_adv_wr),
    .flag_clr    (flag_clr),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .oolock_flag (oolock_flag),
    .hw_sel      (hw_sel),
    .hw_edge     (hw_edge),
    .slip_hold   (slip_hold),
    .debt_zero   (debt_zero),
    .div_cnt     (div_cnt)
);

// File: tb/sync_phase_ctrl_bench.sv
`timescale 1ns/1ps
module sync_phase_ctrl_bench;
    logic clk_sys = 1'b0;
    logic rst_n = 1'b0;
    logic mode_step = 1'b0, mode_auto = 1'b0, mode_fast = 1'b0;
    logic sw_adv_wr = 1'b0, lock_in = 1'b0, flag_clr = 1'b0, pad_in = 1'b0;
    logic sync_clk, oolock_flag, pad_oe, pad_out;

    int ncyc = 0;
    int nslip = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk_sys = ~clk_sys;

    always @(posedge clk_sys) if (rst_n) ncyc <= ncyc + 1;

    sync_phase_ctrl u_sync_phase_ctrl (
        .clk_sys(clk_sys), .rst_n(rst_n), .mode_step(mode_step), .mode_auto(mode_auto),
        .mode_fast(mode_fast), .sw_adv_wr(sw_adv_wr), .lock_in(lock_in), .flag_clr(flag_clr),
        .pad_in(pad_in), .sync_clk(sync_clk), .oolock_flag(oolock_flag),
        .pad_oe(pad_oe), .pad_out(pad_out)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk_sys);
    endtask

    // Compare eight consecutive samples of sync_clk with the arithmetic phase
    task automatic check_phase(input string req);
        for (int i = 0; i < 8; i++) begin
            int e;
            @(negedge clk_sys);
            e = (((ncyc - nslip) & 3) >= 2) ? 1 : 0;
            check(sync_clk == e, req, int'(sync_clk), e);
        end
    endtask

    task automatic pin_pulse(input bit counts);
        @(negedge clk_sys) pad_in = 1'b1;
        idle(3);
        pad_in = 1'b0;
        idle(3);
        if (counts) nslip++;
    endtask

    initial begin
        repeat (100000) @(posedge clk_sys);
        if (!done) begin
            nfail++;
            nchk++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", nchk, nfail);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        // R1 reset state
        check(sync_clk == 1'b0, "R1 sync_clk", int'(sync_clk), 0);
        check(oolock_flag == 1'b0, "R1 flag", int'(oolock_flag), 0);
        check(pad_oe == 1'b1, "R1 pad_oe", int'(pad_oe), 1);
        // R2 free-running divide
        check_phase("R2");

        // R3 software writes: counts and spacings swept
        for (int k = 1; k <= 5; k++) begin
            for (int gap = 0; gap <= 2; gap++) begin
                for (int w = 0; w < k; w++) begin
                    @(negedge clk_sys) sw_adv_wr = 1'b1;
                    nslip++;
                    if (gap > 0) begin
                        @(negedge clk_sys) sw_adv_wr = 1'b0;
                        idle(gap - 1);
                    end
                end
                @(negedge clk_sys) sw_adv_wr = 1'b0;
                idle(8);
                check_phase("R3");
            end
        end

        // R4 long idle keeps phase
        idle(37);
        check_phase("R4");

        // R5 pin edges in step mode
        mode_step = 1'b1;
        idle(3);
        for (int n = 1; n <= 4; n++) begin
            for (int p = 0; p < n; p++) pin_pulse(1'b1);
            idle(4);
            check_phase("R5 step");
        end
        // R5 pin edges ignored in reference and output modes
        mode_step = 1'b0;
        mode_auto = 1'b1;
        idle(3);
        for (int p = 0; p < 3; p++) pin_pulse(1'b0);
        idle(4);
        check_phase("R5 ignored ref");
        mode_auto = 1'b0;
        idle(3);
        for (int p = 0; p < 3; p++) pin_pulse(1'b0);
        idle(4);
        check_phase("R5 ignored out");

        // R6 coincident requests at four starting phases
        mode_step = 1'b1;
        idle(3);
        for (int ph = 0; ph < 4; ph++) begin
            idle(ph);
            @(negedge clk_sys) pad_in = 1'b1;
            idle(2);
            sw_adv_wr = 1'b1;
            @(negedge clk_sys) sw_adv_wr = 1'b0;
            nslip += 2;
            idle(2);
            pad_in = 1'b0;
            idle(8);
            check_phase("R6");
        end

        // R7 pin direction over all mode combinations
        for (int m = 0; m < 8; m++) begin
            bit oe_e;
            mode_step = m[0];
            mode_auto = m[1];
            mode_fast = m[2];
            oe_e = (m == 0);
            for (int l = 0; l < 2; l++) begin
                @(negedge clk_sys) lock_in = l[0];
                idle(2);
                check(pad_oe == oe_e, "R7 pad_oe", int'(pad_oe), int'(oe_e));
                check(pad_out == (oe_e & l[0]), "R7 pad_out", int'(pad_out), int'(oe_e & l[0]));
            end
        end
        mode_step = 1'b0; mode_auto = 1'b0; mode_fast = 1'b0;
        @(negedge clk_sys) flag_clr = 1'b1;
        @(negedge clk_sys) flag_clr = 1'b0;

        // R9 no flag outside step mode
        lock_in = 1'b1;
        idle(3);
        lock_in = 1'b0;
        idle(2);
        check(oolock_flag == 1'b0, "R9 flag", int'(oolock_flag), 0);

        // R8 flag set, sticky, clear, set wins
        mode_step = 1'b1;
        lock_in = 1'b1;
        idle(3);
        lock_in = 1'b0;
        @(negedge clk_sys);
        check(oolock_flag == 1'b1, "R8 set", int'(oolock_flag), 1);
        lock_in = 1'b1;
        idle(4);
        check(oolock_flag == 1'b1, "R8 sticky", int'(oolock_flag), 1);
        flag_clr = 1'b1;
        @(negedge clk_sys) flag_clr = 1'b0;
        check(oolock_flag == 1'b0, "R8 clear", int'(oolock_flag), 0);
        idle(2);
        lock_in = 1'b0;
        flag_clr = 1'b1;
        @(negedge clk_sys) flag_clr = 1'b0;
        check(oolock_flag == 1'b1, "R8 set wins", int'(oolock_flag), 1);
        mode_step = 1'b0;

        check_phase("R4 final");
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule